// File: doc/BRIEF.md
# Byte Lane Write Merge Unit

This unit lets a CPU datapath use byte-sized operands on a memory bus that only moves 16-bit words. The byte order is big-endian: the even byte address names the upper half of a word and the following odd address names the lower half.

On the read side a combinational aligner takes the word on the bus. It moves the addressed byte into bits 15:8 and fills bits 7:0 with zeros. A register operand used directly, or a word-sized operand, passes through unchanged.

On the write side a small sequencer accepts a store request. For a byte store it reads the containing word, puts the new byte into the lane that the address LSB selects, and writes the merged word back. For a word store it issues a single write. A byte store to a register used directly always replaces the upper byte of that register and keeps its lower byte, whatever the LSB of the address.

Top module: `bytelane_unit`

## Requirements
- R1: During and right after synchronous reset, `busy`, `done`, `mem_rd` and `mem_wr` are all 0.
- R2: With `rd_reg_direct`=0, `rd_word_op`=0 and `rd_lane_lsb`=0, `rd_aligned` equals {`mem_rdata`[15:8], 8'h00}.
- R3: With `rd_reg_direct`=0, `rd_word_op`=0 and `rd_lane_lsb`=1, `rd_aligned` equals {`mem_rdata`[7:0], 8'h00}.
- R4: When `rd_reg_direct`=1 or `rd_word_op`=1, `rd_aligned` equals `mem_rdata` unchanged.
- R5: A byte store to an even address replaces the upper byte of the word with `wr_data`[15:8]. A word holding 0x1234 becomes 0x5534 after storing 0x55.
- R6: A byte store to an odd address replaces the lower byte of the word with `wr_data`[15:8]. A word holding 0x1234 becomes 0x1255 after storing 0x55.
- R7: A byte store with `wr_reg_direct`=1 replaces the upper byte and keeps the lower byte for either value of `wr_addr`[0].
- R8: A byte store makes exactly one bus read followed by exactly one bus write. Both go to the word address (`wr_addr` with bit 0 cleared), and `mem_rd` and `mem_wr` are never high together.
- R9: A word store (`wr_word_op`=1) makes no bus read and exactly one bus write of `wr_data` unchanged.
- R10: `busy` is high from the cycle after a request is accepted until the cycle after the write's `mem_ack`. In that cycle `busy` falls and `done` is high for exactly one cycle.
- R11: A `wr_req` raised while `busy` is high is ignored: it causes no extra bus write and leaves its target word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_lane_lsb | input | 1 | Byte address LSB of the operand being read |
| rd_reg_direct | input | 1 | Read operand is a register used directly |
| rd_word_op | input | 1 | Read operand is word-sized |
| rd_aligned | output | 16 | Aligned read operand |
| wr_req | input | 1 | Store request, accepted when idle |
| wr_addr | input | 16 | Byte address of the store |
| wr_data | input | 16 | Store data; a byte store uses bits 15:8 |
| wr_word_op | input | 1 | Store is word-sized |
| wr_reg_direct | input | 1 | Store target is a register used directly |
| busy | output | 1 | Store sequence in progress |
| done | output | 1 | One-cycle pulse when a store completes |
| mem_addr | output | 16 | Word address on the bus (bit 0 always 0) |
| mem_rd | output | 1 | Bus read strobe, held until acknowledged |
| mem_wr | output | 1 | Bus write strobe, held until acknowledged |
| mem_wdata | output | 16 | Bus write data |
| mem_rdata | input | 16 | Bus read data |
| mem_ack | input | 1 | Bus acknowledge for the current strobe |

## Verification
The read aligner and the store sequencer share `mem_rdata`. An operand read can therefore be aligned in the same cycle that the sequencer captures the old word of a read-modify-write. The bench provokes this by changing the read-side controls at random on every cycle while a store is in flight, including the cycle of the read acknowledge. In each of those cycles it compares `rd_aligned` with a reference computed from the bus data. When the store completes, it checks the stored word and the number of reads and writes on the bus, which shows that the sequencer was not disturbed.

// File: rtl/bytelane_pkg.sv
package bytelane_pkg;
    localparam int WORD_W = 16;
    localparam int BYTE_W = 8;
    localparam int LANES  = WORD_W / BYTE_W;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [BYTE_W-1:0] byte_t;

    typedef enum logic [1:0] {
        WS_IDLE     = 2'd0,
        WS_READ_OLD = 2'd1,
        WS_MERGE    = 2'd2,
        WS_WRITE    = 2'd3
    } wr_state_e;

    typedef struct packed {
        word_t addr;
        word_t data;
        logic  word_op;
        logic  reg_direct;
    } store_req_t;

    // A register operand used directly always works on its upper byte.
    function automatic logic pick_low_lane(input logic lsb, input logic reg_direct);
        return lsb & ~reg_direct;
    endfunction

    function automatic word_t word_address(input word_t byte_addr);
        return {byte_addr[WORD_W-1:1], 1'b0};
    endfunction
endpackage

// File: rtl/bl_read_align.sv
module bl_read_align
    import bytelane_pkg::*;
(
    input  word_t bus_word,
    input  logic  lane_lsb,
    input  logic  reg_direct,
    input  logic  word_op,
    output word_t aligned
);
    byte_t picked;

    always_comb begin
        picked = bus_word[WORD_W-1 - int'(lane_lsb)*BYTE_W -: BYTE_W];
        if (word_op || reg_direct) begin
            aligned = bus_word;
        end else begin
            aligned = {picked, {BYTE_W{1'b0}}};
        end
    end
endmodule

// File: rtl/bl_lane_merge.sv
module bl_lane_merge
    import bytelane_pkg::*;
(
    input  word_t old_word,
    input  word_t src_word,
    input  logic  low_lane,
    output word_t merged
);
    byte_t new_byte;
    assign new_byte = src_word[WORD_W-1 -: BYTE_W];

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        localparam int HI = WORD_W - 1 - g * BYTE_W;
        logic hit;
        assign hit = (int'(low_lane) == g);
        assign merged[HI -: BYTE_W] = hit ? new_byte : old_word[HI -: BYTE_W];
    end
endmodule

// File: rtl/bl_wr_seq.sv
module bl_wr_seq
    import bytelane_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       req_valid,
    input  store_req_t req_in,
    input  word_t      mem_rdata,
    input  logic       mem_ack,
    input  word_t      merged,
    output store_req_t req_q,
    output word_t      old_q,
    output word_t      mem_addr,
    output logic       mem_rd,
    output logic       mem_wr,
    output word_t      mem_wdata,
    output logic       busy,
    output logic       done
);
    wr_state_e state;
    word_t     wdata_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= WS_IDLE;
            req_q   <= '0;
            old_q   <= '0;
            wdata_q <= '0;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                WS_IDLE: begin
                    if (req_valid) begin
                        req_q <= req_in;
                        if (req_in.word_op) begin
                            wdata_q <= req_in.data;
                            state   <= WS_WRITE;
                        end else begin
                            state <= WS_READ_OLD;
                        end
                    end
                end
                WS_READ_OLD: begin
                    if (mem_ack) begin
                        old_q <= mem_rdata;
                        state <= WS_MERGE;
                    end
                end
                WS_MERGE: begin
                    wdata_q <= merged;
                    state   <= WS_WRITE;
                end
                WS_WRITE: begin
                    if (mem_ack) begin
                        done  <= 1'b1;
                        state <= WS_IDLE;
                    end
                end
                default: state <= WS_IDLE;
            endcase
        end
    end

    assign mem_rd    = (state == WS_READ_OLD);
    assign mem_wr    = (state == WS_WRITE);
    assign mem_addr  = word_address(req_q.addr);
    assign mem_wdata = wdata_q;
    assign busy      = (state != WS_IDLE);

    // R8
    rd_wr_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd && mem_wr));
    // R8
    even_addr_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_rd || mem_wr) |-> !mem_addr[0]);
    // R8
    write_after_merge_chk: assert property (@(posedge clk) disable iff (rst)
        ($rose(mem_wr) && !req_q.word_op) |-> ($past(state) == WS_MERGE));
    // R9
    word_no_read_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && req_q.word_op) |-> !mem_rd);
    // R10
    ack_ends_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_wr && mem_ack) |=> (!busy && done));
    // R10
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    // R11
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!mem_rd && !mem_wr));
endmodule

// File: rtl/bytelane_unit.sv
module bytelane_unit
    import bytelane_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_lane_lsb,
    input  logic              rd_reg_direct,
    input  logic              rd_word_op,
    output logic [WORD_W-1:0] rd_aligned,
    input  logic              wr_req,
    input  logic [WORD_W-1:0] wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              wr_word_op,
    input  logic              wr_reg_direct,
    output logic              busy,
    output logic              done,
    output logic [WORD_W-1:0] mem_addr,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic [WORD_W-1:0] mem_rdata,
    input  logic              mem_ack
);
    store_req_t req_in;
    store_req_t req_q;
    word_t      old_q;
    word_t      merged;
    logic       low_lane;

    assign req_in = '{addr: wr_addr, data: wr_data,
                      word_op: wr_word_op, reg_direct: wr_reg_direct};

    bl_read_align u_align (
        .bus_word   (mem_rdata),
        .lane_lsb   (rd_lane_lsb),
        .reg_direct (rd_reg_direct),
        .word_op    (rd_word_op),
        .aligned    (rd_aligned)
    );

    assign low_lane = pick_low_lane(req_q.addr[0], req_q.reg_direct);

    bl_lane_merge u_merge (
        .old_word (old_q),
        .src_word (req_q.data),
        .low_lane (low_lane),
        .merged   (merged)
    );

    bl_wr_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .req_valid (wr_req),
        .req_in    (req_in),
        .mem_rdata (mem_rdata),
        .mem_ack   (mem_ack),
        .merged    (merged),
        .req_q     (req_q),
        .old_q     (old_q),
        .mem_addr  (mem_addr),
        .mem_rd    (mem_rd),
        .mem_wr    (mem_wr),
        .mem_wdata (mem_wdata),
        .busy      (busy),
        .done      (done)
    );

    // R2
    aligned_low_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (!rd_reg_direct && !rd_word_op) |-> (rd_aligned[BYTE_W-1:0] == '0));
    // R4
    passthru_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_reg_direct || rd_word_op) |-> (rd_aligned == mem_rdata));
endmodule

// File: tb/tb_bytelane_unit.sv
`timescale 1ns/1ps
module tb_bytelane_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rd_lane_lsb = 1'b0, rd_reg_direct = 1'b0, rd_word_op = 1'b0;
    logic [15:0] rd_aligned;
    logic        wr_req = 1'b0;
    logic [15:0] wr_addr = '0, wr_data = '0;
    logic        wr_word_op = 1'b0, wr_reg_direct = 1'b0;
    logic        busy, done, mem_rd, mem_wr, mem_ack;
    logic [15:0] mem_addr, mem_wdata, mem_rdata;

    // bench memory model, 16 words indexed by address bits 4:1
    logic [15:0] mem [0:15];
    logic [15:0] bus_q = '0;
    logic        ack_q = 1'b0;
    int          wait_cnt = 0;
    int          rd_cnt = 0, wr_cnt = 0;
    logic        poke_en = 1'b0;
    logic [3:0]  poke_idx = '0;
    logic [15:0] poke_val = '0;
    logic        frc_sel = 1'b0;
    logic [15:0] frc_val = '0;

    int checks = 0, errors = 0;
    bit timed_out = 1'b0;

    assign mem_ack   = ack_q;
    assign mem_rdata = frc_sel ? frc_val : bus_q;

    always #2 clk = ~clk;

    bytelane_unit dut (
        .clk(clk), .rst(rst),
        .rd_lane_lsb(rd_lane_lsb), .rd_reg_direct(rd_reg_direct),
        .rd_word_op(rd_word_op), .rd_aligned(rd_aligned),
        .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data),
        .wr_word_op(wr_word_op), .wr_reg_direct(wr_reg_direct),
        .busy(busy), .done(done),
        .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack)
    );

    always @(negedge clk) begin
        if (poke_en) mem[poke_idx] <= poke_val;
        if (rst || ack_q) begin
            ack_q <= 1'b0;
        end else if (mem_rd || mem_wr) begin
            if (wait_cnt == 0) begin
                ack_q <= 1'b1;
                if (mem_wr) begin
                    mem[mem_addr[4:1]] <= mem_wdata;
                    wr_cnt <= wr_cnt + 1;
                end else begin
                    bus_q  <= mem[mem_addr[4:1]];
                    rd_cnt <= rd_cnt + 1;
                end
                wait_cnt <= int'($urandom % 3);
            end else begin
                wait_cnt <= wait_cnt - 1;
            end
        end
    end

    function automatic logic [15:0] ref_align(input logic [15:0] w, input logic lsb,
                                              input logic rdir, input logic wop);
        if (rdir || wop) return w;
        return lsb ? {w[7:0], 8'h00} : {w[15:8], 8'h00};
    endfunction

    function automatic logic [15:0] ref_store(input logic [15:0] old, input logic [15:0] d,
                                              input logic lsb, input logic wop, input logic rdir);
        if (wop) return d;
        if (rdir || !lsb) return {d[15:8], old[7:0]};
        return {old[15:8], d[15:8]};
    endfunction

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic poke(input logic [3:0] idx, input logic [15:0] val);
        @(negedge clk);
        poke_en = 1'b1; poke_idx = idx; poke_val = val;
        @(negedge clk);
        poke_en = 1'b0;
    endtask

    task automatic read_check(input logic [15:0] w, input logic lsb,
                              input logic rdir, input logic wop, input string req);
        frc_sel = 1'b1; frc_val = w;
        rd_lane_lsb = lsb; rd_reg_direct = rdir; rd_word_op = wop;
        #1;
        check(req, rd_aligned, ref_align(w, lsb, rdir, wop));
        frc_sel = 1'b0;
    endtask

    // one store; intrude raises a competing request during the busy window
    task automatic do_store(input logic [15:0] addr, input logic [15:0] data,
                            input logic wop, input logic rdir, input bit intrude,
                            input string req);
        logic [15:0] old_w, exp_w, other_old;
        logic [3:0]  other_idx;
        int r0, w0, n;
        bit first;
        other_idx = addr[4:1] ^ 4'h5;
        @(negedge clk);
        old_w = mem[addr[4:1]];
        other_old = mem[other_idx];
        exp_w = ref_store(old_w, data, addr[0], wop, rdir);
        r0 = rd_cnt; w0 = wr_cnt;
        wr_addr = addr; wr_data = data; wr_word_op = wop; wr_reg_direct = rdir;
        wr_req = 1'b1;
        @(negedge clk);
        wr_req = 1'b0;
        check("R10 busy after accept", {15'b0, busy}, 16'd1);
        n = 0; first = 1'b1;
        while (busy && n < 100) begin
            if (intrude && first) begin
                wr_addr = {addr[15:5], other_idx, 1'b0};
                wr_data = 16'hA5A5; wr_word_op = 1'b1; wr_req = 1'b1;
            end else begin
                wr_req = 1'b0;
            end
            first = 1'b0;
            rd_lane_lsb = 1'($urandom); rd_reg_direct = 1'($urandom); rd_word_op = 1'($urandom);
            #1;
            check("R2/R3/R4 concurrent align", rd_aligned,
                  ref_align(mem_rdata, rd_lane_lsb, rd_reg_direct, rd_word_op));
            @(negedge clk);
            n++;
        end
        wr_req = 1'b0;
        check("R10 done with busy fall", {14'b0, busy, done}, 16'd1);
        check(req, mem[addr[4:1]], exp_w);
        check(wop ? "R9 read count" : "R8 read count", 16'(rd_cnt - r0), wop ? 16'd0 : 16'd1);
        check("R8/R9 write count", 16'(wr_cnt - w0), 16'd1);
        if (intrude) check("R11 ignored target", mem[other_idx], other_old);
        @(negedge clk);
        check("R10 done one cycle", {15'b0, done}, 16'd0);
    endtask

    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i < 16; i++) mem[i] = 16'(i * 16'h1111);
        repeat (3) @(negedge clk);
        check("R1 reset outputs", {12'b0, busy, done, mem_rd, mem_wr}, 16'd0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 after reset", {12'b0, busy, done, mem_rd, mem_wr}, 16'd0);

        // directed read alignment
        read_check(16'h1234, 1'b0, 1'b0, 1'b0, "R2 even lane");
        read_check(16'h1234, 1'b1, 1'b0, 1'b0, "R3 odd lane");
        read_check(16'h1234, 1'b1, 1'b1, 1'b0, "R4 register direct");
        read_check(16'hBEEF, 1'b1, 1'b0, 1'b1, "R4 word op");

        // directed stores
        poke(4'h0, 16'h1234);
        do_store(16'h1000, 16'h5500, 1'b0, 1'b0, 1'b0, "R5 even store");
        poke(4'h0, 16'h1234);
        do_store(16'h1001, 16'h5500, 1'b0, 1'b0, 1'b0, "R6 odd store");
        poke(4'h1, 16'hABCD);
        do_store(16'h1003, 16'h5577, 1'b0, 1'b1, 1'b0, "R7 register odd address");
        poke(4'h2, 16'hABCD);
        do_store(16'h1004, 16'h9911, 1'b0, 1'b1, 1'b0, "R7 register even address");
        do_store(16'h1006, 16'hCAFE, 1'b1, 1'b0, 1'b0, "R9 word store");
        do_store(16'h1009, 16'h3300, 1'b0, 1'b0, 1'b1, "R11 store while busy");

        // random mix
        for (int k = 0; k < 60; k++) begin
            logic [15:0] a, d;
            logic wo, rdir;
            a = {11'h080, 5'($urandom)};
            d = 16'($urandom);
            wo = ($urandom % 4) == 0;
            rdir = ($urandom % 3) == 0;
            do_store(a, d, wo, rdir, (k % 7) == 3 && !wo,
                     wo ? "R9 random" : (rdir ? "R7 random" : (a[0] ? "R6 random" : "R5 random")));
            read_check(16'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), "R2/R3/R4 random");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        timed_out = 1'b1;
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule